// File: doc/BRIEF.md
# Inverted-Polarity Serial Frame Transmitter

This block sends one byte at a time over a single serial line. The line rests low. A frame is a high start bit, then the eight data bits with the least significant bit first, then a low stop bit. A rising edge on the request input starts a frame, and the byte on the parallel data input is captured at that moment. The request may stay high for longer than a whole bit, so the block reacts only to its rising edge and never to its level.

Bit timing comes from an external periodic tick strobe, which is one clock wide. Every bit lasts a fixed number of ticks, set by a parameter with a default of 16. With a 0.1 ms tick this gives a 1.6 ms bit. A busy flag is high for the whole frame. A new request that arrives while a frame is on the line is dropped.

Top module: `serial_frame_tx`

## Requirements
- R1: While reset is held and on the first clock after it, `ser_out` is 0 and `busy` is 0.
- R2: Whenever `busy` is 0, `ser_out` is 0 (line idle low).
- R3: A 0-to-1 change on `go` starts a frame. `busy` and `ser_out` both go to 1 on the third rising clock edge after `go` rises: two synchroniser stages, then the state register.
- R4: A frame is the start bit (value 1), then data bits D0 through D7 in that order, then the stop bit (value 0).
- R5: Each bit stays on the line for exactly TICKS_PER_BIT tick pulses (default 16). `busy` falls on the clock edge that takes the last tick of the stop bit.
- R6: A `go` input held high after its rising edge never starts a second frame.
- R7: A rising edge of `go` while `busy` is 1 is ignored. No extra frame follows.
- R8: The byte on `data_in` is captured at the starting edge. Changes on `data_in` during a frame do not alter the bits sent.
- R9: `busy` stays 1 from the start bit through the end of the stop bit.
- R10: During a frame, `ser_out` changes only on a clock edge at which `tick` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-clock timing strobe; each bit lasts TICKS_PER_BIT of these |
| go | input | 1 | Transmit request, asynchronous; a rising edge starts a frame |
| data_in | input | DATA_W | Byte to send, captured at the starting edge |
| ser_out | output | 1 | Serial line, idle low |
| busy | output | 1 | High while a frame is being sent |

## Verification
The first result appears three clock edges after `go` rises. At that point `busy` and the start bit are expected together. The bench checks `busy` one cycle before that and then on that exact cycle.

After that, the bench counts time in tick pulses rather than in clock cycles. Each bit is sampled on the falling edge that follows its eighth tick. The end of the frame is checked on the clock edge that takes the sixteenth tick of the stop bit: `busy` must still be high at the falling edge before it and low at the falling edge after it.

A scoreboard queue holds the bytes that are due. Any frame that appears when the queue is empty is reported, which covers the retrigger cases.

// File: rtl/sftx_pkg.sv
// Package: shared types for the serial frame transmitter.
// Assumes: nothing beyond the standard language.
package sftx_pkg;
    // Phases of one frame on the line
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2,
        PH_STOP  = 2'd3
    } phase_t;
endpackage

// File: rtl/sftx_go_detect.sv
// Module: sftx_go_detect
// Brings the asynchronous request into the clock domain through a chain of
// SYNC_STAGES flops, then flags its rising edge for one cycle.
// Assumes: the request is held high for several clocks.
module sftx_go_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_async,
    output logic go_rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Synchroniser chain and previous-value register for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], go_async};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Edge pulse: synchronised level is high, previous sample was low
    always_comb go_rise = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/sftx_bit_timer.sv
// Module: sftx_bit_timer
// Counts tick strobes while a frame runs. Pulses bit_end on the clock
// that takes the last tick of a bit.
// Assumes: TICKS_PER_BIT >= 2; count is cleared whenever run is low.
module sftx_bit_timer #(
    parameter int TICKS_PER_BIT = 16,
    localparam int CNT_W = $clog2(TICKS_PER_BIT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic bit_end
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Last tick of the current bit
    always_comb bit_end = run & tick & (cnt_q == LAST);

    // Tick counter: clears when idle or at a bit boundary
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (bit_end) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sftx_frame_ctrl.sv
// Module: sftx_frame_ctrl
// Steps through start, data and stop phases. Captures the byte at the
// starting edge and shifts it out with the least significant bit first.
// Assumes: go_rise is a single-cycle pulse; bit_end marks bit boundaries.
module sftx_frame_ctrl
    import sftx_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_rise,
    input  logic              bit_end,
    input  logic [DATA_W-1:0] data_in,
    output logic              run,
    output logic              line
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    phase_t            phase_q;
    logic [DATA_W-1:0] shreg_q;
    logic [IDX_W-1:0]  idx_q;

    // Phase sequencing, byte capture and shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            shreg_q <= '0;
            idx_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (go_rise) begin
                    phase_q <= PH_START;
                    shreg_q <= data_in;
                    idx_q   <= '0;
                end
                PH_START: if (bit_end) phase_q <= PH_DATA;
                PH_DATA: if (bit_end) begin
                    shreg_q <= shreg_q >> 1;
                    if (idx_q == LAST_IDX) phase_q <= PH_STOP;
                    else                   idx_q   <= idx_q + 1'b1;
                end
                PH_STOP: if (bit_end) phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Frame-active flag and line level for the current phase
    always_comb begin
        run = (phase_q != PH_IDLE);
        case (phase_q)
            PH_START: line = 1'b1;
            PH_DATA:  line = shreg_q[0];
            default:  line = 1'b0;
        endcase
    end
endmodule

// File: rtl/serial_frame_tx.sv
// Module: serial_frame_tx (top)
// Inverted-polarity serial transmitter: idle low, start 1, data LSB first,
// stop 0; each bit lasts TICKS_PER_BIT external tick strobes.
// Assumes: tick is one clock wide; go is asynchronous and held for > 1 bit.
module serial_frame_tx #(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              go,
    input  logic [DATA_W-1:0] data_in,
    output logic              ser_out,
    output logic              busy
);
    logic go_edge;
    logic bit_done;
    logic run;

    sftx_go_detect #(.SYNC_STAGES(SYNC_STAGES)) go_det_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_async (go),
        .go_rise  (go_edge)
    );

    sftx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick),
        .bit_end (bit_done)
    );

    sftx_frame_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_rise (go_edge),
        .bit_end (bit_done),
        .data_in (data_in),
        .run     (run),
        .line    (ser_out)
    );

    // Busy mirrors the controller's frame-active flag
    always_comb busy = run;
endmodule

// File: rtl/serial_frame_tx_checker.sv
// Module: serial_frame_tx_checker
// Temporal checks on the transmitter, attached to it by bind.
// Assumes: synchronous active-low reset.
module serial_frame_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic ser_out,
    input logic busy,
    input logic go_edge,
    input logic bit_done
);
    // R2: idle line is low
    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ser_out);

    // R3: a frame only begins after a detected request edge
    p_start_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go_edge));

    // R4: first bit of a frame is high
    p_start_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ser_out);

    // R4: the bit before the line goes idle is the low stop bit
    p_stop_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$past(ser_out));

    // R5: a frame ends only on a tick
    p_end_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tick));

    // R9: busy drops only at a bit boundary
    p_busy_span_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(bit_done));

    // R10: inside a frame the line moves only after a tick
    p_stable_between_ticks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(tick)) |-> $stable(ser_out));
endmodule

bind serial_frame_tx serial_frame_tx_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .ser_out  (ser_out),
    .busy     (busy),
    .go_edge  (go_edge),
    .bit_done (bit_done)
);

// File: tb/serial_frame_tx_tb_top.sv
// Bench for serial_frame_tx: scoreboard of expected bytes, filled by the
// driver and drained by a frame monitor that samples mid-bit.
module serial_frame_tx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TPB        = 16;
    localparam int TICK_DIV   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       go = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       ser_out;
    logic       busy;

    int  checks = 0;
    int  errs   = 0;
    bit  done   = 1'b0;
    logic [7:0] exp_q[$];
    int  div = 0;

    serial_frame_tx #(.DATA_W(8), .TICKS_PER_BIT(TPB)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .go(go),
        .data_in(data_in), .ser_out(ser_out), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tick generator: one-clock strobe every TICK_DIV clocks
    always @(posedge clk) begin
        if (!rst_n) begin
            div  <= 0;
            tick <= 1'b0;
        end else begin
            div  <= (div == TICK_DIV-1) ? 0 : div + 1;
            tick <= (div == TICK_DIV-1);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance until n ticks have been seen at falling edges, then one more edge
    task automatic wait_ticks(input int n);
        int c = 0;
        forever begin
            if (tick) c++;
            if (c == n) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    // Monitor: detects frame start, pops expected byte, checks every bit
    initial begin
        logic prev_busy = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && busy && !prev_busy) begin
                logic [7:0] e;
                logic [9:0] frame;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6/R7 unexpected frame", 1, 0);
                    e = 8'h00;
                end else begin
                    e = exp_q.pop_front();
                end
                frame = {1'b0, e, 1'b1};
                for (int b = 0; b < 10; b++) begin
                    wait_ticks(TPB/2);
                    check(ser_out == frame[b], $sformatf("R4 bit %0d", b), ser_out, frame[b]);
                    check(busy == 1'b1, "R9 busy mid-frame", busy, 1);
                    if (b < 9) wait_ticks(TPB/2);
                end
                wait_ticks(TPB/2 - 1);
                while (!tick) @(negedge clk);
                check(busy == 1'b1, "R5 busy before last stop tick", busy, 1);
                @(negedge clk);
                check(busy == 1'b0, "R5 busy after last stop tick", busy, 0);
                check(ser_out == 1'b0, "R2 line idle after frame", ser_out, 0);
            end
            prev_busy = busy;
        end
    end

    // R10 observer: line changes inside a frame must follow a tick
    initial begin
        logic pb = 1'b0, po = 1'b0, pt = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && busy && pb && ser_out != po)
                check(pt == 1'b1, "R10 change without tick", pt, 1);
            pb = busy; po = ser_out; pt = tick;
        end
    end

    // Driver: pushes the byte, raises go, checks start latency, optional pokes
    task automatic send(input logic [7:0] d, input bit poke);
        bit quiet = 1'b1;
        check(busy == 1'b0, "R2 idle before send", busy, 0);
        exp_q.push_back(d);
        data_in = d;
        go = 1'b1;
        repeat (2) @(negedge clk);
        check(busy == 1'b0, "R3 no start before third edge", busy, 0);
        @(negedge clk);
        check(busy == 1'b1 && ser_out == 1'b1, "R3 start on third edge", {busy, ser_out}, 3);
        if (poke) begin
            repeat (150) @(negedge clk);
            data_in = ~d;                 // R8: data change mid-frame
            go = 1'b0;                    // R7: fresh edge while busy
            repeat (10) @(negedge clk);
            go = 1'b1;
        end
        while (busy) @(negedge clk);
        // R6: go still high, no new frame and line stays low
        repeat (TPB * TICK_DIV * 4) begin
            @(negedge clk);
            if (busy || ser_out) quiet = 1'b0;
        end
        check(quiet, "R6 held go restarts nothing", !quiet, 0);
        go = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    // Main sequence
    initial begin
        repeat (3) @(negedge clk);
        check(ser_out == 1'b0 && busy == 1'b0, "R1 in reset", {busy, ser_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ser_out == 1'b0 && busy == 1'b0, "R1 after reset", {busy, ser_out}, 0);
        repeat (10) @(negedge clk);
        send(8'hA5, 1'b0);
        send(8'h3C, 1'b1);
        send(8'h00, 1'b0);
        send(8'hFF, 1'b1);
        send(8'h01, 1'b0);
        send(8'h80, 1'b0);
        check(exp_q.size() == 0, "R4 all frames seen", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule